// File: doc/BRIEF.md
# Indexed Audio Codec Control Register Interface

This block is the host-side register front end of an audio codec. The host sees four byte-wide direct ports, selected by a 2-bit offset. Offset 0 is an index pointer and offset 1 is a data window. Together they reach a bank of 32 indirect 8-bit control registers. Offset 2 is a status port whose bit 0 is the interrupt flag. Offset 3 is a programmed-I/O data port that reads as zero. Each access is one byte wide and is presented for one cycle with `bus_sel` high. Read data is combinational while the read is presented. Any side effect of an access, such as a counter decrement or a flag clear, takes effect at the clock edge that ends the access.

The block holds the control state that the rest of the codec uses. It exports the sample-format register, the playback-enable bit, the interrupt-enable bit and a registered, level-high interrupt request. The DMA engine signals the end of a playback block with `dma_done`, and the host clears the interrupt through the status port or through the alternate status register. The block also emulates a calibration-in-progress flag. Driver software polls this flag after it enters mode-change.

Top module: `codec_regif`

## Requirements
- R1: After reset the index pointer reads 0x40. The interrupt request is low. The indirect registers read 0x88 at indexes 2–5, 18 and 19, 0x80 at indexes 6 and 7, 0x08 at index 9, 0x8A at index 12, and 0xA0 at indexes 25 and 26. All other indexes read 0x00.
- R2: A write to the index pointer stores bits 6:0. Bit 7 is discarded and always reads back as 0.
- R3: The indirect index is the low 4 bits of the index pointer while the extended-mode bit (bit 6 of register 12) is 0. While that bit is 1, the index is the low 5 bits.
- R4: In register 12 only bit 6 can be written. Register 11 ignores writes. Writes to indexes 22, 27 and 29 are discarded, so those registers keep reading 0x00.
- R5: A write to register 9 always stores bit 5 as 0. Output `play_en` follows register 9 bit 0, and `irq_en` follows register 10 bit 1.
- R6: Register 8 (format, driven on `fmt_reg`) takes a written byte whole while index-pointer bit 6 (mode-change) is 1. Otherwise, while register 24 bit 4 is 1, it takes only bits 7:4 and keeps its old bits 3:0. In every other case the write leaves it unchanged.
- R7: A write to the index pointer that takes bit 6 from 0 to 1 loads the calibration counter with 1 when register 9 bits 4:3 are nonzero. A read of register 11 while the counter is nonzero returns bit 5 set and decrements the counter. Other reads of register 11 return the stored value.
- R8: Any write to the status port clears the interrupt flag (status bit 0 and the `irq` output) and clears bits 6:4 of register 24.
- R9: A write to register 24 that takes its bit 4 from 1 to 0 clears the interrupt flag.
- R10: A `dma_done` pulse sets the interrupt flag and register 24 bit 4 at that edge. It takes priority over any clear in the same cycle. `irq` equals the flag, and the status port reads the flag in bit 0 with bits 7:1 zero.
- R11: The programmed-I/O data port always reads 0x00, and writes to it change no register or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Direct port offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid while a read is presented |
| dma_done | input | 1 | Playback block-complete pulse from the DMA side |
| fmt_reg | output | 8 | Current format register |
| play_en | output | 1 | Playback enable |
| irq_en | output | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request, level high, registered |

## Verification
The properties assume that every input is at a known level once reset is released. They also assume that a single access is presented per cycle, so an index change, a data access and a status write never share an edge. The stimulus drives each access as a single-cycle strobe away from the clock edge and keeps `bus_addr` and `bus_wdata` defined at all times. It uses one directed cycle to combine `dma_done` with a status write, so that the set-over-clear priority is exercised within these assumptions.

// File: rtl/codec_regif_pkg.sv
package codec_regif_pkg;

  localparam int DATA_W    = 8;
  localparam int NUM_IREGS = 32;
  localparam int IDX_W     = $clog2(NUM_IREGS);

  // Indexes whose behaviour is special.
  localparam int IX_FORMAT  = 8;
  localparam int IX_IFCFG   = 9;
  localparam int IX_PINCTL  = 10;
  localparam int IX_CALSTAT = 11;
  localparam int IX_MODEID  = 12;
  localparam int IX_RSV_A   = 22;
  localparam int IX_ALTSTAT = 24;
  localparam int IX_RSV_B   = 27;
  localparam int IX_RSV_C   = 29;

  // Bit positions that neighbouring logic decodes.
  localparam int B_MCE     = 6;  // index pointer: mode-change enable
  localparam int B_EXTMODE = 6;  // register 12: extended index width
  localparam int B_PMCE    = 4;  // register 24: playback-only change / playback flag
  localparam int B_CAL     = 5;  // register 11 read: calibration in progress
  localparam int B_CFGRSV  = 5;  // register 9: reserved, forced low

  typedef struct packed {
    logic              take;
    logic [DATA_W-1:0] val;
  } ireg_wr_t;

  function automatic logic [DATA_W-1:0] ireg_reset(input int idx);
    case (idx)
      2, 3, 4, 5, 18, 19: return 8'h88;
      6, 7:               return 8'h80;
      IX_IFCFG:           return 8'h08;
      IX_MODEID:          return 8'h8A;
      25, 26:             return 8'hA0;
      default:            return 8'h00;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] eff_index(input logic [DATA_W-1:0] ptr,
                                                 input logic ext_mode);
    logic [IDX_W-1:0] r;
    r = ptr[IDX_W-1:0];
    if (!ext_mode) r[IDX_W-1] = 1'b0;
    return r;
  endfunction

  function automatic ireg_wr_t ireg_write(input logic [IDX_W-1:0] idx,
                                          input logic [DATA_W-1:0] old,
                                          input logic [DATA_W-1:0] din,
                                          input logic mce,
                                          input logic pmce);
    ireg_wr_t r;
    r.take = 1'b1;
    r.val  = din;
    case (int'(idx))
      IX_CALSTAT, IX_RSV_A, IX_RSV_B, IX_RSV_C: r.take = 1'b0;
      IX_FORMAT: begin
        if (mce)       r.val = din;
        else if (pmce) r.val = {din[7:4], old[3:0]};
        else           r.take = 1'b0;
      end
      IX_IFCFG: begin
        r.val = din;
        r.val[B_CFGRSV] = 1'b0;
      end
      IX_MODEID: begin
        r.val = old;
        r.val[B_EXTMODE] = din[B_EXTMODE];
      end
      default: r.val = din;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/codec_index_ctl.sv
module codec_index_ctl
  import codec_regif_pkg::*;
#(
  parameter int CAL_W    = 2,
  parameter int CAL_LOAD = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cal_arm_ok,
  input  logic              cal_rd,
  output logic [DATA_W-1:0] ptr_q,
  output logic              mce_rise,
  output logic [CAL_W-1:0]  cal_cnt
);
  localparam logic [CAL_W-1:0] CAL_INIT = CAL_W'(CAL_LOAD);
  localparam logic [CAL_W-1:0] CAL_ONE  = CAL_W'(1);

  assign mce_rise = ptr_wr && !ptr_q[B_MCE] && wdata[B_MCE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= 8'h40;
    end else if (ptr_wr) begin
      ptr_q <= {1'b0, wdata[DATA_W-2:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cal_cnt <= '0;
    end else if (mce_rise && cal_arm_ok) begin
      cal_cnt <= CAL_INIT;
    end else if (cal_rd && (cal_cnt != '0)) begin
      cal_cnt <= cal_cnt - CAL_ONE;
    end
  end
endmodule

// File: rtl/codec_reg_bank.sv
module codec_reg_bank
  import codec_regif_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [IDX_W-1:0]                   widx,
  input  logic [DATA_W-1:0]                  wdata,
  input  logic                               mce,
  input  logic                               stat_clr,
  input  logic                               pi_set,
  output logic [NUM_IREGS-1:0][DATA_W-1:0]   regs_q,
  output logic                               pi_fall
);
  logic pmce;
  assign pmce = regs_q[IX_ALTSTAT][B_PMCE];

  assign pi_fall = wr_en && (int'(widx) == IX_ALTSTAT) &&
                   regs_q[IX_ALTSTAT][B_PMCE] && !wdata[B_PMCE];

  for (genvar g = 0; g < NUM_IREGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] nxt;
    logic              hit;
    ireg_wr_t          wr;

    assign hit = wr_en && (widx == IDX_W'(g));
    assign wr  = ireg_write(IDX_W'(g), q, wdata, mce, pmce);

    if (g == IX_ALTSTAT) begin : g_alt
      always_comb begin
        nxt = q;
        if (hit && wr.take) nxt = wr.val;
        if (stat_clr)       nxt[6:4] = 3'b000;
        if (pi_set)         nxt[B_PMCE] = 1'b1;
      end
    end else begin : g_plain
      always_comb begin
        nxt = q;
        if (hit && wr.take) nxt = wr.val;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) q <= ireg_reset(g);
      else        q <= nxt;
    end

    assign regs_q[g] = q;
  end
endmodule

// File: rtl/codec_irq_ctl.sv
module codec_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic int_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       int_q <= 1'b0;
    else if (set_evt) int_q <= 1'b1;
    else if (clr_evt) int_q <= 1'b0;
  end
endmodule

// File: rtl/codec_regif.sv
module codec_regif
  import codec_regif_pkg::*;
#(
  parameter int CAL_W    = 2,
  parameter int CAL_LOAD = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dma_done,
  output logic [DATA_W-1:0] fmt_reg,
  output logic              play_en,
  output logic              irq_en,
  output logic              irq
);
  localparam logic [1:0] P_INDEX = 2'd0;
  localparam logic [1:0] P_DATA  = 2'd1;
  localparam logic [1:0] P_STAT  = 2'd2;

  logic [NUM_IREGS-1:0][DATA_W-1:0] regs_q;
  logic [DATA_W-1:0] ptr_q;
  logic [IDX_W-1:0]  eidx;
  logic [CAL_W-1:0]  cal_cnt;
  logic              mce_rise;
  logic              ptr_wr, data_wr, data_rd, stat_wr;
  logic              cal_rd_evt, fmt_blk_evt, pi_fall, int_q;
  logic [DATA_W-1:0] ireg_rd;

  assign ptr_wr  = bus_sel &&  bus_wr && (bus_addr == P_INDEX);
  assign data_wr = bus_sel &&  bus_wr && (bus_addr == P_DATA);
  assign data_rd = bus_sel && !bus_wr && (bus_addr == P_DATA);
  assign stat_wr = bus_sel &&  bus_wr && (bus_addr == P_STAT);

  assign eidx = eff_index(ptr_q, regs_q[IX_MODEID][B_EXTMODE]);

  assign cal_rd_evt  = data_rd && (int'(eidx) == IX_CALSTAT) && (cal_cnt != '0);
  assign fmt_blk_evt = data_wr && (int'(eidx) == IX_FORMAT) &&
                       !ptr_q[B_MCE] && !regs_q[IX_ALTSTAT][B_PMCE];

  codec_index_ctl #(.CAL_W(CAL_W), .CAL_LOAD(CAL_LOAD)) u_index (
    .clk        (clk),
    .rst_n      (rst_n),
    .ptr_wr     (ptr_wr),
    .wdata      (bus_wdata),
    .cal_arm_ok (regs_q[IX_IFCFG][4:3] != 2'b00),
    .cal_rd     (cal_rd_evt),
    .ptr_q      (ptr_q),
    .mce_rise   (mce_rise),
    .cal_cnt    (cal_cnt)
  );

  codec_reg_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (data_wr),
    .widx     (eidx),
    .wdata    (bus_wdata),
    .mce      (ptr_q[B_MCE]),
    .stat_clr (stat_wr),
    .pi_set   (dma_done),
    .regs_q   (regs_q),
    .pi_fall  (pi_fall)
  );

  codec_irq_ctl u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (dma_done),
    .clr_evt (stat_wr || pi_fall),
    .int_q   (int_q)
  );

  always_comb begin
    ireg_rd = regs_q[eidx];
    if ((int'(eidx) == IX_CALSTAT) && (cal_cnt != '0)) ireg_rd[B_CAL] = 1'b1;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        P_INDEX: bus_rdata = ptr_q;
        P_DATA:  bus_rdata = ireg_rd;
        P_STAT:  bus_rdata = {7'b0, int_q};
        default: bus_rdata = '0;
      endcase
    end
  end

  assign fmt_reg = regs_q[IX_FORMAT];
  assign play_en = regs_q[IX_IFCFG][0];
  assign irq_en  = regs_q[IX_PINCTL][1];
  assign irq     = int_q;
endmodule

// File: rtl/codec_regif_chk.sv
module codec_regif_chk
  import codec_regif_pkg::*;
#(
  parameter int CAL_W = 2
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             bus_sel,
  input logic                             bus_wr,
  input logic [1:0]                       bus_addr,
  input logic [DATA_W-1:0]                bus_rdata,
  input logic                             dma_done,
  input logic [DATA_W-1:0]                fmt_reg,
  input logic                             irq,
  input logic [CAL_W-1:0]                 cal_cnt,
  input logic                             cal_rd_evt,
  input logic                             fmt_blk_evt,
  input logic [NUM_IREGS-1:0][DATA_W-1:0] regs_q
);
  localparam logic [CAL_W-1:0] ONE = CAL_W'(1);

  assert_ptr_bit7_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 2'd0) |-> !bus_rdata[7]);

  assert_rsv_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_q[IX_RSV_A] == 8'h00) && (regs_q[IX_RSV_B] == 8'h00) && (regs_q[IX_RSV_C] == 8'h00));

  assert_cfg_bit5_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !regs_q[IX_IFCFG][B_CFGRSV]);

  assert_fmt_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_blk_evt |=> $stable(fmt_reg));

  assert_cal_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_rd_evt |=> (cal_cnt == $past(cal_cnt) - ONE));

  assert_stat_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd2 && !dma_done) |=> !irq);

  assert_dma_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> (irq && regs_q[IX_ALTSTAT][B_PMCE]));

  assert_pio_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 2'd3) |-> (bus_rdata == 8'h00));
endmodule

bind codec_regif codec_regif_chk #(.CAL_W(CAL_W)) u_chk (.*);

// File: tb/codec_regif_test.sv
module codec_regif_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       dma_done = 1'b0;
  logic [7:0] fmt_reg;
  logic       play_en, irq_en, irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;

  logic [7:0] m_reg [32];
  logic [7:0] m_ptr;
  int         m_cal;
  logic       m_int;

  codec_regif uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_done(dma_done), .fmt_reg(fmt_reg), .play_en(play_en),
    .irq_en(irq_en), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] init_val(int i);
    if ((i >= 2 && i <= 5) || i == 18 || i == 19) return 8'h88;
    if (i == 6 || i == 7) return 8'h80;
    if (i == 9) return 8'h08;
    if (i == 12) return 8'h8A;
    if (i == 25 || i == 26) return 8'hA0;
    return 8'h00;
  endfunction

  function automatic int cur_index();
    return m_reg[12][6] ? int'(m_ptr % 32) : int'(m_ptr % 16);
  endfunction

  function automatic logic [7:0] model_read(logic [1:0] a);
    int i;
    case (a)
      2'd0: return m_ptr;
      2'd1: begin
        i = cur_index();
        if (i == 11 && m_cal != 0) return m_reg[11] | 8'h20;
        return m_reg[i];
      end
      2'd2: return {7'b0, m_int};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic check_outs(string req);
    check(req, "fmt_reg", fmt_reg, m_reg[8]);
    check("R5", "play_en", {7'b0, play_en}, {7'b0, m_reg[9][0]});
    check("R5", "irq_en", {7'b0, irq_en}, {7'b0, m_reg[10][1]});
    check("R10", "irq", {7'b0, irq}, {7'b0, m_int});
  endtask

  task automatic model_write(logic [1:0] a, logic [7:0] d, logic dma);
    int i;
    case (a)
      2'd0: begin
        if (!m_ptr[6] && d[6] && m_reg[9][4:3] != 2'b00) m_cal = 1;
        m_ptr = d & 8'h7F;
      end
      2'd1: begin
        i = cur_index();
        case (i)
          11, 22, 27, 29: ;
          8: if (m_ptr[6]) m_reg[8] = d;
             else if (m_reg[24][4]) m_reg[8] = {d[7:4], m_reg[8][3:0]};
          9: m_reg[9] = d & 8'hDF;
          12: m_reg[12] = (m_reg[12] & 8'hBF) | (d & 8'h40);
          24: begin
            if (m_reg[24][4] && !d[4]) m_int = 1'b0;
            m_reg[24] = d;
          end
          default: m_reg[i] = d;
        endcase
      end
      2'd2: begin
        m_int = 1'b0;
        m_reg[24] = m_reg[24] & 8'h8F;
      end
      default: ;
    endcase
    if (dma) begin
      m_int = 1'b1;
      m_reg[24] = m_reg[24] | 8'h10;
    end
  endtask

  task automatic bus_write(string req, logic [1:0] a, logic [7:0] d, logic dma = 1'b0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; dma_done = dma;
    @(posedge clk);
    model_write(a, d, dma);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; dma_done = 1'b0;
    #1 check_outs(req);
  endtask

  task automatic bus_read(string req, logic [1:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 check(req, "rdata", bus_rdata, model_read(a));
    @(posedge clk);
    if (a == 2'd1 && cur_index() == 11 && m_cal != 0) m_cal--;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic dma_pulse();
    @(negedge clk);
    dma_done = 1'b1;
    @(posedge clk);
    model_write(2'd3, 8'h00, 1'b1);
    @(negedge clk);
    dma_done = 1'b0;
    #1 check_outs("R10");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 32; i++) m_reg[i] = init_val(i);
    m_ptr = 8'h40; m_cal = 0; m_int = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1 check_outs("R1");

    // R1: reset state, low half in 4-bit mode, then high half in extended mode.
    bus_read("R1", 2'd0);
    for (int i = 0; i < 16; i++) begin
      bus_write("R1", 2'd0, 8'h40 | i[7:0]);
      bus_read("R1", 2'd1);
    end
    bus_write("R3", 2'd0, 8'h4C);
    bus_write("R3", 2'd1, 8'h40);
    for (int i = 16; i < 32; i++) begin
      bus_write("R1", 2'd0, 8'h40 | i[7:0]);
      bus_read("R1", 2'd1);
    end
    bus_read("R1", 2'd2);

    // R2: bit 7 dropped.
    bus_write("R2", 2'd0, 8'hD3);
    bus_read("R2", 2'd0);

    // R3: leave extended mode; pointer 0x58 aliases index 8.
    bus_write("R3", 2'd0, 8'h4C);
    bus_write("R4", 2'd1, 8'hFF);
    bus_read("R4", 2'd1);
    bus_write("R3", 2'd0, 8'h4C);
    bus_write("R3", 2'd1, 8'h00);
    bus_write("R3", 2'd0, 8'h58);
    bus_read("R3", 2'd1);

    // R7: rising mode-change with reg9 bits 4:3 = 01 arms one calibration read.
    bus_write("R7", 2'd0, 8'h0B);
    bus_write("R7", 2'd0, 8'h4B);
    bus_read("R7", 2'd1);
    bus_read("R7", 2'd1);
    bus_write("R4", 2'd1, 8'hFF);
    bus_read("R4", 2'd1);

    // R5: reserved bit of reg 9; irq enable through reg 10.
    bus_write("R5", 2'd0, 8'h49);
    bus_write("R5", 2'd1, 8'hFF);
    bus_read("R5", 2'd1);
    bus_write("R5", 2'd0, 8'h4A);
    bus_write("R5", 2'd1, 8'h02);

    // R6: gating of the format register.
    bus_write("R6", 2'd0, 8'h48);
    bus_write("R6", 2'd1, 8'h3C);
    bus_write("R6", 2'd0, 8'h08);
    bus_write("R6", 2'd1, 8'h5A);
    bus_write("R6", 2'd0, 8'h4C);
    bus_write("R6", 2'd1, 8'h40);
    bus_write("R6", 2'd0, 8'h18);
    bus_write("R6", 2'd1, 8'h10);
    bus_write("R6", 2'd0, 8'h08);
    bus_write("R6", 2'd1, 8'hA5);

    // R9, R10, R8: interrupt set and clear paths.
    dma_pulse();
    bus_read("R10", 2'd2);
    bus_write("R9", 2'd0, 8'h18);
    bus_write("R9", 2'd1, 8'h00);
    dma_pulse();
    bus_write("R8", 2'd2, 8'h00);
    bus_write("R10", 2'd2, 8'h00, 1'b1);
    bus_read("R10", 2'd2);
    bus_write("R8", 2'd2, 8'hFF);
    bus_read("R8", 2'd1);

    // R11: PIO port.
    bus_write("R11", 2'd3, 8'hFF);
    bus_read("R11", 2'd3);
    bus_read("R11", 2'd0);

    // Random mix.
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [7:0] d;
      op = int'($urandom % 100);
      d  = 8'($urandom);
      if (op < 25)      bus_write("R3", 2'd0, d);
      else if (op < 55) bus_write("R6", 2'd1, d);
      else if (op < 80) bus_read("R7", 2'($urandom % 4));
      else if (op < 88) bus_write("R8", 2'd2, d);
      else if (op < 95) dma_pulse();
      else              bus_write("R11", 2'd3, d);
    end

    finish_run();
  end
endmodule